// File: doc/BRIEF.md
# Table-Encoded Bus Clock Divider

This block produces the clock for a peripheral bus by dividing its input clock by a ratio picked from a small code table. Software writes a 2-bit code into a control register. The code does not map to a plain power of two. Codes 0 and 1 both give divide-by-2, code 2 gives divide-by-4, and code 3 gives divide-by-8. The output clock always has a 50% duty cycle.

A code written while the output is running does not take effect at once. It waits until the output period in progress has finished, so the bus never sees a shortened or stretched half period. A period begins at a rising output edge. The register reads back the code exactly as it was written, so software can still tell code 0 from code 1 even though both behave the same.

Top module: `bus_clk_divider`

## Requirements
- R1: The divide code is held in bits 1:0 of the control register, and a read returns the last code written, bit for bit. Codes 0 and 1 stay distinguishable.
- R2: Every register bit above bit 1 reads as zero, whatever value was written to it.
- R3: Codes 0 and 1 divide by 2: the output is high for 1 input cycle and then low for 1 input cycle.
- R4: Code 2 divides by 4 (2 cycles high, 2 low). Code 3 divides by 8 (4 cycles high, 4 low).
- R5: For every ratio, the high time of each output period equals its low time.
- R6: A period uses the code that the register held just before the rising output edge that starts that period. A write that lands during a period takes effect only when the next period starts.
- R7: While reset is held, the register reads 0 and the output is low. On the first clock edge after reset is released, the output rises and starts its first period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Write strobe for the control register |
| reg_wdata | input | DATA_W | Write data; only bits 1:0 are stored |
| reg_rdata | output | DATA_W | Read data: the stored code, with upper bits zero |
| clk_div_o | output | 1 | Divided output clock |

## Verification
The bench builds the block with the default DATA_W of 32. Random write data then fills all 30 unused upper bits, so every write exercises R2. Writes come at random points within output periods and sometimes in back-to-back cycles. This places code changes right at and just before a period boundary, where the rule of R6 is easiest to break. Each completed period is measured against the code the readback showed one cycle before its rising edge.

// File: rtl/bus_clk_divider.sv
module bus_clk_divider #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              clk_div_o
);
  logic [1:0] cfg_code;
  logic [1:0] act_code;
  logic [1:0] cnt;
  logic [2:0] half;
  logic       term;

  always_comb begin
    case (act_code)
      2'd2:    half = 3'd2;
      2'd3:    half = 3'd4;
      default: half = 3'd1;
    endcase
  end

  assign term      = ({1'b0, cnt} == half - 3'd1);
  assign reg_rdata = {{(DATA_W-2){1'b0}}, cfg_code};

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_code <= 2'd0;
    else if (reg_we) cfg_code <= reg_wdata[1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= 2'd0;
      clk_div_o <= 1'b0;
      act_code  <= 2'd0;
    end else if (term) begin
      cnt       <= 2'd0;
      clk_div_o <= ~clk_div_o;
      if (!clk_div_o) act_code <= cfg_code;
    end else begin
      cnt <= cnt + 2'd1;
    end
  end

  assert_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_we) && $past(rst_n) |-> reg_rdata[1:0] == $past(reg_wdata[1:0]));

  assert_switch_at_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && act_code != $past(act_code) |-> $rose(clk_div_o));

  assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, cnt} < half);

  assert_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && clk_div_o != $past(clk_div_o) |-> $past(term));
endmodule

// File: tb/tb_bus_clk_divider.sv
module tb_bus_clk_divider;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_we = 1'b0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              clk_div_o;

  int checks = 0;
  int fails  = 0;

  bus_clk_divider #(.DATA_W(DATA_W)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .clk_div_o(clk_div_o)
  );

  always #2.5 clk = ~clk;

  function automatic int half_of(input logic [1:0] code);
    if (code == 2'd2) return 2;
    if (code == 2'd3) return 4;
    return 1;
  endfunction

  task automatic check(input string req, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // period monitor (R3, R4, R5, R6)
  logic       prev_s = 1'b0;
  logic [1:0] prev_cfg = 2'd0;
  logic [1:0] per_code = 2'd0;
  bit         have_per = 1'b0;
  int         hi = 0, lo = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_s = 1'b0; prev_cfg = 2'd0; have_per = 1'b0; hi = 0; lo = 0;
    end else begin
      if (clk_div_o && !prev_s) begin
        if (have_per) begin
          if (per_code < 2) check("R3 high", hi == 1, hi, 1);
          else check("R4 high", hi == half_of(per_code), hi, half_of(per_code));
          check("R6 low", lo == half_of(per_code), lo, half_of(per_code));
          check("R5 duty", hi == lo, hi, lo);
        end
        per_code = prev_cfg;
        have_per = 1'b1;
        hi = 1; lo = 0;
      end else if (clk_div_o) hi++;
      else lo++;
      prev_s   = clk_div_o;
      prev_cfg = reg_rdata[1:0];
    end
  end

  task automatic write_reg(input logic [DATA_W-1:0] v);
    reg_we = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
    check("R1 readback", reg_rdata[1:0] == v[1:0], reg_rdata[1:0], v[1:0]);
    check("R2 upper zero", reg_rdata[DATA_W-1:2] == '0, reg_rdata[DATA_W-1:2], 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    idle(3);
    check("R7 reset rdata", reg_rdata == '0, reg_rdata, 0);
    check("R7 reset out", clk_div_o == 1'b0, clk_div_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 first rise", clk_div_o == 1'b1, clk_div_o, 1);
    idle(10);
    write_reg({30'h2aaaaaaa, 2'd1}); idle(20);
    write_reg({30'h15555555, 2'd0}); idle(20);
    write_reg(32'hffff_fffe);        idle(40);
    write_reg(32'hffff_ffff);        idle(60);
    write_reg(32'h0000_0001);        write_reg(32'h0000_0003); idle(40);
    write_reg(32'h8000_0002);        idle(40);
    for (int k = 0; k < 400; k++) begin
      write_reg($urandom);
      idle($urandom_range(0, 12));
    end
    idle(30);
    finish_run();
  end
endmodule